// File: doc/BRIEF.md
# Synthesizer Divider Programming Interface

This block sits between a host and the divider chain of an integer-N frequency synthesizer. It accepts divider settings in one of three ways: as a 20-bit word shifted in bit by bit, as three bytes written on a parallel bus with one write strobe per byte, or as static levels on dedicated pins. From those settings it drives the main divide value M, the swallow count A, the reference divide value R and the active-low prescaler enable to the counters.

Two 20-bit settings registers support frequency hopping. A working register receives the loads. A shadow register takes a copy of it on a transfer strobe, and a select input picks which of the two feeds the counters. This lets the host stage the next channel while the current one is still in use. A separate 8-bit control register carries power-down, a continuous counter-load flag, two selects for the monitor data output and a monitor-output disable. In serial operation this register is itself double buffered: its bits are shifted into a staging stage and become visible only when the enable strobe falls.

Every strobe, clock and data input is asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the block acts on edges detected in the system-clock domain. The system clock must run at least eight times faster than the serial clock.

Top module: `synth_prog_if`

## Requirements
- R1: While reset is asserted and after it is released, with no load and mode_direct low, m_val, a_val, r_val, pre_en_n and all five control outputs are 0.
- R2: mode_direct=1 selects pin mode regardless of mode_serial. With mode_direct=0, mode_serial=1 selects serial mode and mode_serial=0 selects parallel mode.
- R3: In serial mode, while ser_wr and enh_wr are both low, each rising edge of ser_clk shifts ser_data into the working register. The first of the 20 bits ends at bit 19. Word layout: bits 19:18 = R[5:4], 17:16 = M[8:7], 15 = prescaler enable (active low), 14:8 = M[6:0], 7:4 = R[3:0], 3:0 = A[3:0].
- R4: The shadow register copies the working register on a rising edge of ser_wr in serial mode, or of hop_wr in serial or parallel mode.
- R5: In parallel mode, a rising edge of par_wr_hi loads par_data[3:0] into bits 19:16. A rising edge of par_wr_mid loads par_data[7:0] into bits 15:8. A rising edge of par_wr_lo loads par_data[7:0] into bits 7:0.
- R6: Outside pin mode, use_primary=1 drives the outputs from the working register and use_primary=0 drives them from the shadow register.
- R7: In serial mode, with enh_wr high and ser_wr low, each rising edge of ser_clk shifts ser_data into a control staging register, first bit at bit 7. The control register takes the staged value only on a falling edge of enh_wr.
- R8: In parallel mode, a rising edge of enh_wr loads par_data[7:0] into the control register.
- R9: Control outputs are active only while enh_en_n is low. Then pwr_down = bit 3, cnt_load = bit 4, dout_msel = bit 5, dout_presc = bit 6 and fpfc_off = bit 7. Bits 2:0 affect no output.
- R10: In pin mode, M = {2'b00, dir_m}, R = {2'b00, dir_r}, A = dir_a and pre_en_n = dir_pre_en_n.
- R11: A register update caused by a strobe edge appears at the outputs on the third rising system-clock edge after the input change.
- R12: A strobe has no effect in a mode that does not use it: the parallel byte strobes in serial mode, and ser_clk in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_direct | input | 1 | Pin mode select |
| mode_serial | input | 1 | Serial (1) or parallel (0) when not in pin mode |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, first bit most significant |
| ser_wr | input | 1 | Serial write strobe; rising edge copies working to shadow |
| enh_wr | input | 1 | Control register write enable / strobe |
| par_data | input | 8 | Parallel data byte |
| par_wr_hi | input | 1 | Strobe for bits 19:16 |
| par_wr_mid | input | 1 | Strobe for bits 15:8 |
| par_wr_lo | input | 1 | Strobe for bits 7:0 |
| hop_wr | input | 1 | Working-to-shadow transfer strobe |
| use_primary | input | 1 | 1 = working register, 0 = shadow register |
| enh_en_n | input | 1 | Active-low control-bit enable |
| dir_m | input | 7 | Pin-mode M value |
| dir_r | input | 4 | Pin-mode R value |
| dir_a | input | 4 | Pin-mode A value |
| dir_pre_en_n | input | 1 | Pin-mode prescaler enable, active low |
| m_val | output | 9 | Main divider value |
| a_val | output | 4 | Swallow count |
| r_val | output | 6 | Reference divider value |
| pre_en_n | output | 1 | Prescaler enable, active low |
| pwr_down | output | 1 | Power-down control |
| cnt_load | output | 1 | Continuous counter-load control |
| dout_msel | output | 1 | Route modulus select to monitor output |
| dout_presc | output | 1 | Route prescaler output to monitor output |
| fpfc_off | output | 1 | Disable divider monitor outputs |

## Verification
Each strobe edge needs two synchronizer flops and one register stage. A register load therefore shows at the outputs on the third system-clock edge after the input change. In pin mode, and when use_primary or enh_en_n changes, the outputs follow combinationally. The bench drives every input on a falling clock edge and holds each strobe level for four system cycles, so every edge is detected cleanly. It samples outputs on falling edges only after enough edges for the result to be due. The hop-transfer test samples both the second edge, where the old value must still show, and the third edge, where the new value must be present.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int M_W      = 9;
  localparam int A_W      = 4;
  localparam int R_W      = 6;
  localparam int DIR_M_W  = 7;
  localparam int DIR_R_W  = 4;
  localparam int PAR_W    = 8;
  localparam int ENH_W    = 8;
  localparam int CFG_W    = M_W + A_W + R_W + 1;
  // word layout
  localparam int POS_A    = 0;
  localparam int POS_RLO  = POS_A + A_W;
  localparam int POS_MLO  = POS_RLO + DIR_R_W;
  localparam int POS_PRE  = POS_MLO + DIR_M_W;
  localparam int POS_MHI  = POS_PRE + 1;
  localparam int POS_RHI  = POS_MHI + (M_W - DIR_M_W);
  localparam int HI_W     = CFG_W - POS_MHI;
  // control register bit roles
  localparam int ENH_PD    = 3;
  localparam int ENH_LOAD  = 4;
  localparam int ENH_MSEL  = 5;
  localparam int ENH_PRESC = 6;
  localparam int ENH_OFF   = 7;

  typedef enum logic [1:0] {MODE_PAR = 2'b00, MODE_SER = 2'b01, MODE_DIR = 2'b10} load_mode_e;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
    logic [R_W-1:0] r;
    logic           pre_n;
  } div_cfg_t;

  function automatic load_mode_e decode_mode(input logic dir, input logic ser);
    if (dir)      return MODE_DIR;
    else if (ser) return MODE_SER;
    else          return MODE_PAR;
  endfunction

  function automatic div_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    div_cfg_t c;
    c.a     = w[POS_A +: A_W];
    c.r     = {w[POS_RHI +: R_W-DIR_R_W], w[POS_RLO +: DIR_R_W]};
    c.m     = {w[POS_MHI +: M_W-DIR_M_W], w[POS_MLO +: DIR_M_W]};
    c.pre_n = w[POS_PRE];
    return c;
  endfunction
endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/sp_cfg_regs.sv
module sp_cfg_regs
  import sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  load_mode_e        mode,
  input  logic              sclk_rise,
  input  logic              sdata,
  input  logic              swr_lvl,
  input  logic              swr_rise,
  input  logic              ewr_lvl,
  input  logic              ewr_rise,
  input  logic              ewr_fall,
  input  logic              hop_rise,
  input  logic              phi_rise,
  input  logic              pmid_rise,
  input  logic              plo_rise,
  input  logic [PAR_W-1:0]  pdata,
  output logic [CFG_W-1:0]  prim_o,
  output logic [CFG_W-1:0]  sec_o,
  output logic [ENH_W-1:0]  enh_o
);
  logic [CFG_W-1:0] prim_q, prim_d, sec_q, sec_d;
  logic [ENH_W-1:0] stg_q, stg_d, enh_q, enh_d;
  logic             ser_m, par_m;
  logic             shift_p, shift_e, copy_en, cap_ser, cap_par;

  assign ser_m   = (mode == MODE_SER);
  assign par_m   = (mode == MODE_PAR);
  assign shift_p = ser_m & sclk_rise & ~swr_lvl & ~ewr_lvl;
  assign shift_e = ser_m & sclk_rise & ~swr_lvl &  ewr_lvl;
  assign copy_en = (ser_m & swr_rise) | ((ser_m | par_m) & hop_rise);
  assign cap_ser = ser_m & ewr_fall;
  assign cap_par = par_m & ewr_rise;

  always_comb begin
    prim_d = prim_q;
    if (shift_p) prim_d = {prim_q[CFG_W-2:0], sdata};
    if (par_m) begin
      if (phi_rise)  prim_d[POS_MHI +: HI_W]  = pdata[HI_W-1:0];
      if (pmid_rise) prim_d[POS_MLO +: PAR_W] = pdata;
      if (plo_rise)  prim_d[POS_A +: PAR_W]   = pdata;
    end
    sec_d = copy_en ? prim_q : sec_q;
    stg_d = shift_e ? {stg_q[ENH_W-2:0], sdata} : stg_q;
    enh_d = enh_q;
    if (cap_ser)      enh_d = stg_q;
    else if (cap_par) enh_d = pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= '0;
      sec_q  <= '0;
      stg_q  <= '0;
      enh_q  <= '0;
    end else begin
      prim_q <= prim_d;
      sec_q  <= sec_d;
      stg_q  <= stg_d;
      enh_q  <= enh_d;
    end
  end

  assign prim_o = prim_q;
  assign sec_o  = sec_q;
  assign enh_o  = enh_q;

  assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_p |=> (prim_q == {$past(prim_q[CFG_W-2:0]), $past(sdata)}));
  assert_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |=> (sec_q == $past(prim_q)));
  assert_sec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_en |=> $stable(sec_q));
  assert_enh_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_ser | cap_par) |=> $stable(enh_q));
  assert_par_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_m & !sclk_rise) |=> $stable(prim_q));
endmodule

// File: rtl/sp_out_sel.sv
module sp_out_sel
  import sp_pkg::*;
(
  input  load_mode_e          mode,
  input  logic                use_primary,
  input  logic                enh_en_n,
  input  logic [CFG_W-1:0]    prim,
  input  logic [CFG_W-1:0]    sec,
  input  logic [ENH_W-1:0]    enh,
  input  logic [DIR_M_W-1:0]  dir_m,
  input  logic [DIR_R_W-1:0]  dir_r,
  input  logic [A_W-1:0]      dir_a,
  input  logic                dir_pre_en_n,
  output div_cfg_t            cfg_o,
  output logic [4:0]          ctl_o
);
  div_cfg_t reg_cfg, pin_cfg;

  always_comb begin
    reg_cfg       = unpack_cfg(use_primary ? prim : sec);
    pin_cfg.m     = {{(M_W-DIR_M_W){1'b0}}, dir_m};
    pin_cfg.r     = {{(R_W-DIR_R_W){1'b0}}, dir_r};
    pin_cfg.a     = dir_a;
    pin_cfg.pre_n = dir_pre_en_n;
    cfg_o         = (mode == MODE_DIR) ? pin_cfg : reg_cfg;
    ctl_o         = enh_en_n ? 5'b0
                  : {enh[ENH_OFF], enh[ENH_PRESC], enh[ENH_MSEL], enh[ENH_LOAD], enh[ENH_PD]};
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import sp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_direct,
  input  logic               mode_serial,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_wr,
  input  logic               enh_wr,
  input  logic [PAR_W-1:0]   par_data,
  input  logic               par_wr_hi,
  input  logic               par_wr_mid,
  input  logic               par_wr_lo,
  input  logic               hop_wr,
  input  logic               use_primary,
  input  logic               enh_en_n,
  input  logic [DIR_M_W-1:0] dir_m,
  input  logic [DIR_R_W-1:0] dir_r,
  input  logic [A_W-1:0]     dir_a,
  input  logic               dir_pre_en_n,
  output logic [M_W-1:0]     m_val,
  output logic [A_W-1:0]     a_val,
  output logic [R_W-1:0]     r_val,
  output logic               pre_en_n,
  output logic               pwr_down,
  output logic               cnt_load,
  output logic               dout_msel,
  output logic               dout_presc,
  output logic               fpfc_off
);
  localparam int STB_N = 7;
  localparam int SY_W  = STB_N + 1 + PAR_W;

  logic            rst_q1, rst_q2;
  logic [SY_W-1:0] sy_in, sy_lvl, sy_rise, sy_fall;
  logic [CFG_W-1:0] prim, sec;
  logic [ENH_W-1:0] enh;
  load_mode_e      mode;
  div_cfg_t        cfg;
  logic [4:0]      ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  assign sy_in = {par_data, ser_data, hop_wr, par_wr_lo, par_wr_mid, par_wr_hi,
                  enh_wr, ser_wr, ser_clk};
  assign mode  = decode_mode(mode_direct, mode_serial);

  sp_sync_edge #(.W(SY_W)) u_sync (
    .clk(clk), .rst_n(rst_q2), .async_i(sy_in),
    .lvl_o(sy_lvl), .rise_o(sy_rise), .fall_o(sy_fall)
  );

  sp_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_q2), .mode(mode),
    .sclk_rise(sy_rise[0]), .sdata(sy_lvl[STB_N]),
    .swr_lvl(sy_lvl[1]), .swr_rise(sy_rise[1]),
    .ewr_lvl(sy_lvl[2]), .ewr_rise(sy_rise[2]), .ewr_fall(sy_fall[2]),
    .hop_rise(sy_rise[6]), .phi_rise(sy_rise[3]), .pmid_rise(sy_rise[4]),
    .plo_rise(sy_rise[5]), .pdata(sy_lvl[SY_W-1 -: PAR_W]),
    .prim_o(prim), .sec_o(sec), .enh_o(enh)
  );

  sp_out_sel u_sel (
    .mode(mode), .use_primary(use_primary), .enh_en_n(enh_en_n),
    .prim(prim), .sec(sec), .enh(enh),
    .dir_m(dir_m), .dir_r(dir_r), .dir_a(dir_a), .dir_pre_en_n(dir_pre_en_n),
    .cfg_o(cfg), .ctl_o(ctl)
  );

  assign m_val      = cfg.m;
  assign a_val      = cfg.a;
  assign r_val      = cfg.r;
  assign pre_en_n   = cfg.pre_n;
  assign pwr_down   = ctl[0];
  assign cnt_load   = ctl[1];
  assign dout_msel  = ctl[2];
  assign dout_presc = ctl[3];
  assign fpfc_off   = ctl[4];

  assert_pin_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_q2)
    mode_direct |-> (m_val[M_W-1:DIR_M_W] == '0 && r_val[R_W-1:DIR_R_W] == '0));
  assert_ctl_gate_R9: assert property (@(posedge clk) disable iff (!rst_q2)
    enh_en_n |-> !(pwr_down | cnt_load | dout_msel | dout_presc | fpfc_off));
  assert_reset_clear_R1: assert property (@(posedge clk)
    (!rst_q2 && !mode_direct) |-> (m_val == '0 && a_val == '0 && r_val == '0 && !pre_en_n));
endmodule

// File: tb/tb_synth_prog_if.sv
module tb_synth_prog_if;
  logic clk = 1'b0;
  logic rst_n;
  logic mode_direct, mode_serial, ser_clk, ser_data, ser_wr, enh_wr;
  logic [7:0] par_data;
  logic par_wr_hi, par_wr_mid, par_wr_lo, hop_wr, use_primary, enh_en_n;
  logic [6:0] dir_m;
  logic [3:0] dir_r, dir_a;
  logic dir_pre_en_n;
  logic [8:0] m_val;
  logic [3:0] a_val;
  logic [5:0] r_val;
  logic pre_en_n, pwr_down, cnt_load, dout_msel, dout_presc, fpfc_off;

  int vectors = 0;
  int miss = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  synth_prog_if dut (.*);

  function automatic logic [19:0] pack(input logic [5:0] r, input logic [8:0] m,
                                       input logic [3:0] a, input logic pre);
    return {r[5:4], m[8:7], pre, m[6:0], r[3:0], a};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_cfg(input string tag, input logic [8:0] em, input logic [3:0] ea,
                         input logic [5:0] er, input logic ep);
    vectors++;
    if (m_val !== em || a_val !== ea || r_val !== er || pre_en_n !== ep) begin
      miss++;
      $display("FAIL %s: got m=%0d a=%0d r=%0d pre=%0b exp m=%0d a=%0d r=%0d pre=%0b",
               tag, m_val, a_val, r_val, pre_en_n, em, ea, er, ep);
    end
  endtask

  task automatic chk_ctl(input string tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {fpfc_off, dout_presc, dout_msel, cnt_load, pwr_down};
    vectors++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: got ctl=%b exp ctl=%b", tag, got, exp);
    end
  endtask

  task automatic ser_bit(input logic b);
    ser_data = b; tick(4);
    ser_clk = 1'b1; tick(4);
    ser_clk = 1'b0;
  endtask

  task automatic ser_word(input logic [19:0] w);
    for (int i = 19; i >= 0; i--) ser_bit(w[i]);
    tick(4);
  endtask

  task automatic strobe(ref logic s);
    s = 1'b1; tick(4);
    s = 1'b0; tick(4);
  endtask

  task automatic par_word(input logic [19:0] w);
    par_data = {4'h0, w[19:16]}; strobe(par_wr_hi);
    par_data = w[15:8];          strobe(par_wr_mid);
    par_data = w[7:0];           strobe(par_wr_lo);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tick(3);
    chk_cfg("R1 during reset", 9'd0, 4'd0, 6'd0, 1'b0);
    chk_ctl("R1 ctl during reset", 5'b0);
    rst_n = 1'b1; tick(4);
    chk_cfg("R1 after reset", 9'd0, 4'd0, 6'd0, 1'b0);
  endtask

  // same setting through all three paths (R2, R3, R5, R10)
  task automatic t_three_paths;
    mode_direct = 0; mode_serial = 1; use_primary = 1;
    ser_word(pack(6'd9, 9'd100, 4'd5, 1'b1));
    chk_cfg("R3 serial load", 9'd100, 4'd5, 6'd9, 1'b1);
    rst_n = 0; tick(2); rst_n = 1; tick(4);
    mode_serial = 0;
    par_word(pack(6'd9, 9'd100, 4'd5, 1'b1));
    chk_cfg("R5 parallel load", 9'd100, 4'd5, 6'd9, 1'b1);
    mode_direct = 1; mode_serial = 1;
    dir_m = 7'd100; dir_r = 4'd9; dir_a = 4'd5; dir_pre_en_n = 1'b1; tick(1);
    chk_cfg("R10 pin mode", 9'd100, 4'd5, 6'd9, 1'b1);
    dir_m = 7'd127; dir_r = 4'd15; dir_a = 4'd0; dir_pre_en_n = 1'b0; tick(1);
    chk_cfg("R10 pin mode max", 9'd127, 4'd0, 6'd15, 1'b0);
    mode_direct = 0; mode_serial = 0; tick(1);
    chk_cfg("R2 back to parallel", 9'd100, 4'd5, 6'd9, 1'b1);
  endtask

  task automatic t_serial_wide;
    mode_serial = 1; use_primary = 1;
    ser_word(pack(6'd37, 9'd300, 4'd7, 1'b0));
    chk_cfg("R3 upper bits", 9'd300, 4'd7, 6'd37, 1'b0);
    use_primary = 0; tick(1);
    chk_cfg("R6 shadow untouched", 9'd0, 4'd0, 6'd0, 1'b0);
    strobe(ser_wr);
    chk_cfg("R4 ser_wr copy", 9'd300, 4'd7, 6'd37, 1'b0);
    par_data = 8'hFF; strobe(par_wr_mid);
    use_primary = 1; tick(1);
    chk_cfg("R12 par strobe in serial", 9'd300, 4'd7, 6'd37, 1'b0);
  endtask

  task automatic t_pingpong;
    mode_serial = 0; use_primary = 0;
    par_word(pack(6'd63, 9'd511, 4'd15, 1'b1));
    chk_cfg("R6 shadow keeps old", 9'd300, 4'd7, 6'd37, 1'b0);
    use_primary = 1; tick(1);
    chk_cfg("R6 working new", 9'd511, 4'd15, 6'd63, 1'b1);
    use_primary = 0;
    hop_wr = 1'b1; tick(2);
    chk_cfg("R11 not yet at edge 2", 9'd300, 4'd7, 6'd37, 1'b0);
    tick(1);
    chk_cfg("R11 hop copy at edge 3", 9'd511, 4'd15, 6'd63, 1'b1);
    hop_wr = 1'b0; tick(4);
    use_primary = 1;
    ser_bit(1'b0); tick(4);
    chk_cfg("R12 ser_clk in parallel", 9'd511, 4'd15, 6'd63, 1'b1);
  endtask

  task automatic t_enh;
    logic [7:0] v;
    enh_en_n = 1'b0;
    mode_serial = 1; v = 8'hA8;
    enh_wr = 1'b1; tick(4);
    for (int i = 7; i >= 0; i--) ser_bit(v[i]);
    tick(4);
    chk_ctl("R7 staged not visible", 5'b00000);
    enh_wr = 1'b0; tick(4);
    chk_ctl("R7 capture on fall", 5'b10101);
    use_primary = 1; tick(1);
    chk_cfg("R7 working untouched by ctl shift", 9'd511, 4'd15, 6'd63, 1'b1);
    mode_serial = 0; par_data = 8'h57; strobe(enh_wr);
    chk_ctl("R8 parallel latch, R9 reserved bits", 5'b01010);
    enh_en_n = 1'b1; tick(1);
    chk_ctl("R9 gated off", 5'b00000);
    enh_en_n = 1'b0; tick(1);
    chk_ctl("R9 gated on", 5'b01010);
  endtask

  initial begin
    rst_n = 0; mode_direct = 0; mode_serial = 0; ser_clk = 0; ser_data = 0;
    ser_wr = 0; enh_wr = 0; par_data = 0; par_wr_hi = 0; par_wr_mid = 0;
    par_wr_lo = 0; hop_wr = 0; use_primary = 1; enh_en_n = 1;
    dir_m = 0; dir_r = 0; dir_a = 0; dir_pre_en_n = 0;
    t_reset();
    t_three_paths();
    t_serial_wide();
    t_pingpong();
    t_enh();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    end
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      miss++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end
endmodule